// File: doc/BRIEF.md
# Chained Receive Slot Buffer

This block keeps received frames in a small bank of slots. Each slot holds three things. The first is an acceptance filter, made of a stored identifier, a per-bit mask, an enable and an end-of-chain marker. The second is the last frame captured into the slot: its identifier, length code and up to eight data bytes. The third is a set of flags: new-data, interrupt-pending and message-lost. Software gives several slots the same filter values to turn them into one queue. The slot with the lowest index in that group is filled first. The slot marked end-of-chain closes the group.

Frames arrive on a valid/ready port, and the block can accept one frame per clock. A frame is written into the lowest-indexed slot that matches it and is free to take it. A slot that is not the end of its chain is free only while its new-data flag is clear. The end-of-chain slot is always free. Once every earlier slot in a chain holds unread data, each further frame overwrites the end slot.

Software reads any slot by number on a combinational read port. In the same access it can ask for the slot's new-data flag and interrupt flag to be cleared. The flags that come back are the values from before the clear. Software sets up the filters through a one-cycle configuration write.

Top module: `rxq_buffer`

## Requirements
- R1: A slot accepts a frame only while its enable bit is 1 and the frame passes the slot's filter. Passing means `((frame_id ^ slot_id) & slot_mask) == 0`, so a mask bit of 1 makes that identifier bit count and a mask bit of 0 ignores it.
- R2: Each accepted frame is written into exactly one slot. That slot is the lowest-indexed slot that both matches the frame and is free to take it.
- R3: Writing a frame into a slot sets the slot's new-data and interrupt-pending flags. It also stores the frame's identifier, length code and data, which the read port returns from the next cycle onward.
- R4: A slot whose end-of-chain bit is 0 takes no frame while its new-data flag is 1. The frame goes to the next matching slot with a higher index.
- R5: A slot whose end-of-chain bit is 1 takes a matching frame even when its new-data flag is 1, and the new frame replaces the old contents.
- R6: Writing a frame into a slot whose new-data flag is already 1 sets that slot's lost flag. A clear-new-data request or a configuration write to the slot resets the lost flag.
- R7: The read port shows the contents and flags of slot `rd_slot` in the same cycle, with no register in the path. In a cycle that clears flags, the flags shown are still the values from before the clear.
- R8: When `rd_req` is 1, `rd_clr_new` clears the new-data and lost flags of the selected slot at the clock edge, and `rd_clr_pend` clears its interrupt-pending flag at the clock edge. The two requests work independently of each other.
- R9: A frame that matches no slot that is free to take it is dropped. No slot changes.
- R10: If a frame is written into a slot in the same cycle that a read asks to clear that slot's flags, the write wins. The new-data and interrupt-pending flags stay at 1.
- R11: `rx_ready` is 0 in any cycle with a configuration write and 1 in every other cycle. A configuration write loads the slot's identifier, mask, end-of-chain bit and enable bit, and it clears all three flags of that slot.
- R12: After reset, every slot is disabled, all flags are 0 and all stored fields are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_slot | input | 3 | Slot selected for the configuration write |
| cfg_id | input | 11 | Filter identifier |
| cfg_mask | input | 11 | Filter mask, where 1 means the bit is compared |
| cfg_eob | input | 1 | End-of-chain marker |
| cfg_en | input | 1 | Slot enable |
| rx_valid | input | 1 | A frame is present on the receive port |
| rx_ready | output | 1 | The block can accept a frame this cycle |
| rx_id | input | 11 | Frame identifier |
| rx_dlc | input | 4 | Frame length code |
| rx_data | input | 64 | Frame payload |
| rd_req | input | 1 | Enables the clear requests of this cycle |
| rd_slot | input | 3 | Slot shown on the read port |
| rd_clr_new | input | 1 | Clear the new-data and lost flags |
| rd_clr_pend | input | 1 | Clear the interrupt-pending flag |
| rd_id | output | 11 | Stored frame identifier |
| rd_dlc | output | 4 | Stored length code |
| rd_data | output | 64 | Stored payload |
| rd_new | output | 1 | New-data flag, value before any clear |
| rd_pend | output | 1 | Interrupt-pending flag, value before any clear |
| rd_lost | output | 1 | Lost flag, value before any clear |

## Verification
Two things can hit the same slot in one cycle: a frame write and a software clear of that slot's flags. The bench provokes this deliberately. It fills the first three slots of a chain so that the next frame must go to the end slot, and in that same cycle it asks to clear the end slot. It then checks that new-data and pending both read back as 1 and that the lost flag records the overwrite. Later, a sweep over all 2048 identifiers issues a clear on a rotating slot with every frame. This produces many more of these coincidences, as well as clears that land on slots the frame does not touch. After every step, a model in the bench that follows the requirements is compared with all eight slots on the read port.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  localparam int ID_LIMIT = 29;

  typedef struct packed {
    logic en;
    logic eob;
    logic newd;
    logic pend;
    logic lost;
  } slot_flags_t;

  // masked identifier compare: mask bit 1 means the bit must agree
  function automatic logic id_accepts(input logic [ID_LIMIT-1:0] frame_id,
                                      input logic [ID_LIMIT-1:0] filt_id,
                                      input logic [ID_LIMIT-1:0] filt_mask);
    return ((frame_id ^ filt_id) & filt_mask) == '0;
  endfunction

  // a slot takes a frame when it matches and is not a locked inner link
  function automatic logic slot_free(input logic matched, input logic newd, input logic eob);
    return matched && (!newd || eob);
  endfunction

endpackage

// File: rtl/rxq_pick.sv
module rxq_pick #(
  parameter int N = 8
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] grant
);
  logic found;

  always_comb begin
    grant = '0;
    found = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && !found) begin
        grant[i] = 1'b1;
        found    = 1'b1;
      end
    end
  end

endmodule

// File: rtl/rxq_slot.sv
module rxq_slot
  import rxq_pkg::*;
#(
  parameter int ID_W  = 11,
  parameter int DLC_W = 4,
  parameter int DW    = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_hit,
  input  logic [ID_W-1:0]  cfg_id,
  input  logic [ID_W-1:0]  cfg_mask,
  input  logic             cfg_eob,
  input  logic             cfg_en,
  input  logic [ID_W-1:0]  frame_id,
  input  logic [DLC_W-1:0] frame_dlc,
  input  logic [DW-1:0]    frame_data,
  input  logic             store,
  input  logic             clr_new,
  input  logic             clr_pend,
  output logic             free,
  output slot_flags_t      flags,
  output logic [ID_W-1:0]  held_id,
  output logic [DLC_W-1:0] held_dlc,
  output logic [DW-1:0]    held_data
);
  logic [ID_W-1:0] filt_id_q;
  logic [ID_W-1:0] filt_mask_q;
  slot_flags_t     fl_q;
  logic            matched;

  assign matched = fl_q.en && id_accepts(ID_LIMIT'(frame_id), ID_LIMIT'(filt_id_q),
                                         ID_LIMIT'(filt_mask_q));
  assign free    = slot_free(matched, fl_q.newd, fl_q.eob);
  assign flags   = fl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filt_id_q   <= '0;
      filt_mask_q <= '0;
      fl_q        <= '0;
      held_id     <= '0;
      held_dlc    <= '0;
      held_data   <= '0;
    end else if (cfg_hit) begin
      filt_id_q   <= cfg_id;
      filt_mask_q <= cfg_mask;
      fl_q.en     <= cfg_en;
      fl_q.eob    <= cfg_eob;
      fl_q.newd   <= 1'b0;
      fl_q.pend   <= 1'b0;
      fl_q.lost   <= 1'b0;
    end else if (store) begin
      held_id   <= frame_id;
      held_dlc  <= frame_dlc;
      held_data <= frame_data;
      fl_q.newd <= 1'b1;
      fl_q.pend <= 1'b1;
      fl_q.lost <= fl_q.lost | fl_q.newd;
    end else begin
      if (clr_new) begin
        fl_q.newd <= 1'b0;
        fl_q.lost <= 1'b0;
      end
      if (clr_pend) fl_q.pend <= 1'b0;
    end
  end

  AST_STORE_SETS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    store |=> (fl_q.newd && fl_q.pend)); // R3
  AST_NO_LOCKED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    store |-> (!fl_q.newd || fl_q.eob)); // R4
  AST_STORE_NEEDS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    store |-> fl_q.en); // R1
  AST_LOST_ON_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (store && fl_q.newd) |=> fl_q.lost); // R6
  AST_STORE_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (store && clr_new) |=> fl_q.newd); // R10
  AST_CLEAR_NEW: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_new && !store && !cfg_hit) |=> (!fl_q.newd && !fl_q.lost)); // R8

endmodule

// File: rtl/rxq_buffer.sv
module rxq_buffer
  import rxq_pkg::*;
#(
  parameter int NUM_SLOTS  = 8,
  parameter int ID_W       = 11,
  parameter int DATA_BYTES = 8,
  parameter int DLC_W      = 4,
  localparam int SW        = $clog2(NUM_SLOTS),
  localparam int DW        = 8 * DATA_BYTES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [SW-1:0]    cfg_slot,
  input  logic [ID_W-1:0]  cfg_id,
  input  logic [ID_W-1:0]  cfg_mask,
  input  logic             cfg_eob,
  input  logic             cfg_en,
  input  logic             rx_valid,
  output logic             rx_ready,
  input  logic [ID_W-1:0]  rx_id,
  input  logic [DLC_W-1:0] rx_dlc,
  input  logic [DW-1:0]    rx_data,
  input  logic             rd_req,
  input  logic [SW-1:0]    rd_slot,
  input  logic             rd_clr_new,
  input  logic             rd_clr_pend,
  output logic [ID_W-1:0]  rd_id,
  output logic [DLC_W-1:0] rd_dlc,
  output logic [DW-1:0]    rd_data,
  output logic             rd_new,
  output logic             rd_pend,
  output logic             rd_lost
);
  logic                 rx_fire;
  logic [NUM_SLOTS-1:0] free_vec;
  logic [NUM_SLOTS-1:0] grant_vec;
  logic [NUM_SLOTS-1:0] store_vec;
  slot_flags_t          s_flags [NUM_SLOTS];
  logic [ID_W-1:0]      s_id    [NUM_SLOTS];
  logic [DLC_W-1:0]     s_dlc   [NUM_SLOTS];
  logic [DW-1:0]        s_data  [NUM_SLOTS];

  assign rx_ready  = !cfg_we;
  assign rx_fire   = rx_valid && rx_ready;
  assign store_vec = grant_vec & {NUM_SLOTS{rx_fire}};

  rxq_pick #(.N(NUM_SLOTS)) u_pick (
    .req   (free_vec),
    .grant (grant_vec)
  );

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    logic cfg_hit_g;
    logic clr_new_g;
    logic clr_pend_g;
    assign cfg_hit_g  = cfg_we && (cfg_slot == SW'(g));
    assign clr_new_g  = rd_req && rd_clr_new  && (rd_slot == SW'(g));
    assign clr_pend_g = rd_req && rd_clr_pend && (rd_slot == SW'(g));

    rxq_slot #(.ID_W(ID_W), .DLC_W(DLC_W), .DW(DW)) u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_hit    (cfg_hit_g),
      .cfg_id     (cfg_id),
      .cfg_mask   (cfg_mask),
      .cfg_eob    (cfg_eob),
      .cfg_en     (cfg_en),
      .frame_id   (rx_id),
      .frame_dlc  (rx_dlc),
      .frame_data (rx_data),
      .store      (store_vec[g]),
      .clr_new    (clr_new_g),
      .clr_pend   (clr_pend_g),
      .free       (free_vec[g]),
      .flags      (s_flags[g]),
      .held_id    (s_id[g]),
      .held_dlc   (s_dlc[g]),
      .held_data  (s_data[g])
    );
  end

  always_comb begin
    rd_id   = s_id[rd_slot];
    rd_dlc  = s_dlc[rd_slot];
    rd_data = s_data[rd_slot];
    rd_new  = s_flags[rd_slot].newd;
    rd_pend = s_flags[rd_slot].pend;
    rd_lost = s_flags[rd_slot].lost;
  end

  AST_ONE_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(store_vec)); // R2
  AST_STORE_NEEDS_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    (|store_vec) |-> (rx_valid && rx_ready)); // R9
  AST_NO_STORE_IN_CFG: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |-> !(|store_vec)); // R11
  AST_FREE_FRAME_STORED: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_fire && (|free_vec)) |-> $countones(store_vec) == 1); // R2

endmodule

// File: tb/tb_rxq_buffer.sv
`timescale 1ns/100ps
module tb_rxq_buffer;
  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_slot = '0;
  logic [10:0] cfg_id = '0, cfg_mask = '0;
  logic        cfg_eob = 1'b0, cfg_en = 1'b0;
  logic        rx_valid = 1'b0;
  logic        rx_ready;
  logic [10:0] rx_id = '0;
  logic [3:0]  rx_dlc = '0;
  logic [63:0] rx_data = '0;
  logic        rd_req = 1'b0;
  logic [2:0]  rd_slot = '0;
  logic        rd_clr_new = 1'b0, rd_clr_pend = 1'b0;
  logic [10:0] rd_id;
  logic [3:0]  rd_dlc;
  logic [63:0] rd_data;
  logic        rd_new, rd_pend, rd_lost;

  int checks = 0;
  int failures = 0;

  // reference state built from the requirements
  logic [10:0] m_fid [N], m_fmask [N];
  logic        m_en [N], m_eob [N], m_new [N], m_pend [N], m_lost [N];
  logic [10:0] m_id [N];
  logic [3:0]  m_dlc [N];
  logic [63:0] m_data [N];

  always #2.5 clk = ~clk;

  rxq_buffer dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_slot(cfg_slot), .cfg_id(cfg_id),
    .cfg_mask(cfg_mask), .cfg_eob(cfg_eob), .cfg_en(cfg_en), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .rx_id(rx_id), .rx_dlc(rx_dlc), .rx_data(rx_data),
    .rd_req(rd_req), .rd_slot(rd_slot), .rd_clr_new(rd_clr_new), .rd_clr_pend(rd_clr_pend),
    .rd_id(rd_id), .rd_dlc(rd_dlc), .rd_data(rd_data), .rd_new(rd_new),
    .rd_pend(rd_pend), .rd_lost(rd_lost)
  );

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int pick_slot(input logic [10:0] id);
    for (int s = 0; s < N; s++) begin
      if (m_en[s] && (((id ^ m_fid[s]) & m_fmask[s]) == 11'd0) && (!m_new[s] || m_eob[s]))
        return s;
    end
    return -1;
  endfunction

  task automatic cmp_all(input string req);
    for (int s = 0; s < N; s++) begin
      rd_slot = 3'(s);
      #0.1;
      chk(rd_new  == m_new[s],  req, 64'(rd_new),  64'(m_new[s]));
      chk(rd_pend == m_pend[s], req, 64'(rd_pend), 64'(m_pend[s]));
      chk(rd_lost == m_lost[s], req, 64'(rd_lost), 64'(m_lost[s]));
      chk(rd_id   == m_id[s],   req, 64'(rd_id),   64'(m_id[s]));
      chk(rd_dlc  == m_dlc[s],  req, 64'(rd_dlc),  64'(m_dlc[s]));
      chk(rd_data == m_data[s], req, rd_data,      m_data[s]);
    end
  endtask

  task automatic configure(input int s, input logic [10:0] id, input logic [10:0] msk,
                           input logic eob, input logic en);
    @(negedge clk);
    cfg_we = 1'b1; cfg_slot = 3'(s); cfg_id = id; cfg_mask = msk; cfg_eob = eob; cfg_en = en;
    rx_valid = 1'b1; rx_id = id; rx_dlc = 4'd5; rx_data = 64'hDEAD;
    #0.1;
    chk(rx_ready == 1'b0, "R11 ready low in cfg", 64'(rx_ready), 64'd0);
    m_fid[s] = id; m_fmask[s] = msk; m_eob[s] = eob; m_en[s] = en;
    m_new[s] = 1'b0; m_pend[s] = 1'b0; m_lost[s] = 1'b0;
    @(negedge clk);
    cfg_we = 1'b0; rx_valid = 1'b0;
  endtask

  // one cycle with an optional frame and an optional read with clears
  task automatic step(input logic fv, input logic [10:0] fid, input logic [3:0] fdlc,
                      input logic [63:0] fdata, input logic rv, input int rs,
                      input logic cn, input logic cp, input string req);
    int tgt;
    @(negedge clk);
    rx_valid = fv; rx_id = fid; rx_dlc = fdlc; rx_data = fdata;
    rd_req = rv; rd_slot = 3'(rs); rd_clr_new = cn; rd_clr_pend = cp;
    #0.1;
    chk(rx_ready == 1'b1, "R11 ready high", 64'(rx_ready), 64'd1);
    if (rv) begin
      chk(rd_new  == m_new[rs],  "R7 pre-clear new",  64'(rd_new),  64'(m_new[rs]));
      chk(rd_pend == m_pend[rs], "R7 pre-clear pend", 64'(rd_pend), 64'(m_pend[rs]));
      chk(rd_data == m_data[rs], "R7 read data",      rd_data,      m_data[rs]);
    end
    tgt = fv ? pick_slot(fid) : -1;
    if (tgt >= 0) begin
      m_lost[tgt] = m_lost[tgt] | m_new[tgt];
      m_new[tgt] = 1'b1; m_pend[tgt] = 1'b1;
      m_id[tgt] = fid; m_dlc[tgt] = fdlc; m_data[tgt] = fdata;
    end
    if (rv && rs != tgt) begin
      if (cn) begin m_new[rs] = 1'b0; m_lost[rs] = 1'b0; end
      if (cp) m_pend[rs] = 1'b0;
    end
    @(negedge clk);
    rx_valid = 1'b0; rd_req = 1'b0; rd_clr_new = 1'b0; rd_clr_pend = 1'b0;
    #0.1;
    cmp_all(req);
  endtask

  function automatic logic [63:0] pay(input int k);
    return 64'(k) * 64'h0101_0101_0101_0101 ^ 64'h0F1E_2D3C_4B5A_6978;
  endfunction

  initial begin
    for (int s = 0; s < N; s++) begin
      m_fid[s] = '0; m_fmask[s] = '0; m_en[s] = 0; m_eob[s] = 0;
      m_new[s] = 0; m_pend[s] = 0; m_lost[s] = 0; m_id[s] = '0; m_dlc[s] = '0; m_data[s] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #0.1;
    chk(rx_ready == 1'b1, "R12 ready after reset", 64'(rx_ready), 64'd1);
    cmp_all("R12 reset state");

    // chain A: slots 0..3 accept 0x120..0x12F; chain B: slots 4,5 exact 0x300;
    // slot 6 single non-end slot for 0x055; slot 7 left disabled
    for (int s = 0; s < 4; s++) configure(s, 11'h120, 11'h7F0, s == 3, 1'b1);
    configure(4, 11'h300, 11'h7FF, 1'b0, 1'b1);
    configure(5, 11'h300, 11'h7FF, 1'b1, 1'b1);
    configure(6, 11'h055, 11'h7FF, 1'b0, 1'b1);
    cmp_all("R11 cfg leaves flags clear");

    // fill chain A in index order, then overwrite its end slot
    for (int k = 0; k < 6; k++)
      step(1'b1, 11'h120 + 11'(k), 4'(k), pay(k), 1'b0, 0, 1'b0, 1'b0, "R2 R3 R4 R5 R6 chain fill");

    // read slot 1 with both clears, then refill it as the lowest free link
    step(1'b0, 11'h0, 4'd0, 64'd0, 1'b1, 1, 1'b1, 1'b1, "R7 R8 clear both");
    step(1'b1, 11'h12A, 4'd7, pay(40), 1'b0, 0, 1'b0, 1'b0, "R4 lowest released link");
    // pending only
    step(1'b0, 11'h0, 4'd0, 64'd0, 1'b1, 0, 1'b0, 1'b1, "R8 clear pend only");
    // same-cycle write and clear on the end slot
    step(1'b1, 11'h12F, 4'd8, pay(41), 1'b1, 3, 1'b1, 1'b1, "R10 write beats clear");
    // chain B and the isolated slot
    step(1'b1, 11'h300, 4'd2, pay(50), 1'b0, 0, 1'b0, 1'b0, "R2 chain B first");
    step(1'b1, 11'h300, 4'd3, pay(51), 1'b0, 0, 1'b0, 1'b0, "R2 chain B second");
    step(1'b1, 11'h301, 4'd3, pay(52), 1'b0, 0, 1'b0, 1'b0, "R1 masked bit mismatch dropped");
    step(1'b1, 11'h055, 4'd1, pay(53), 1'b0, 0, 1'b0, 1'b0, "R1 exact match");
    step(1'b1, 11'h055, 4'd4, pay(54), 1'b0, 0, 1'b0, 1'b0, "R9 locked lone slot drops");
    step(1'b1, 11'h000, 4'd4, pay(55), 1'b0, 0, 1'b0, 1'b0, "R1 R9 disabled slot ignores");

    // sweep every identifier with a rotating clear
    for (int id = 0; id < 2048; id++)
      step(1'b1, 11'(id), 4'(id % 9), pay(id + 100), 1'b1, id % 8, id[3], id[4],
           "R1 R2 R4 R5 R6 R8 R10 sweep");

    configure(3, 11'h120, 11'h7F0, 1'b1, 1'b1);
    cmp_all("R11 cfg clears flags");
    configure(0, 11'h000, 11'h000, 1'b1, 1'b1);
    step(1'b1, 11'h7FF, 4'd6, pay(9), 1'b0, 0, 1'b0, 1'b0, "R1 zero mask accepts all");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule